// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves inbound frames from a byte stream into memory buffers that software hands it through a chain of descriptors. Each descriptor occupies four consecutive 32-bit words at a word address: a status word, a control word, the word address of its data buffer and the word address of a following descriptor. Software marks a descriptor as available by setting status bit 31. The block fetches the descriptor, fills its buffer with the next frame, and then writes a status word that gives the frame length and error flags and returns the descriptor to software in the same write.

Three registers drive it: the address of the first descriptor, a poll-demand strobe and a start bit. The memory port is a simple single-cycle synchronous master: a read returns data on the cycle after the request, and a write takes effect at the clock edge. The stream carries no back-pressure. Bytes that arrive while no descriptor is ready are discarded up to the end of their frame.

The controller is a state machine with seven states. ST_IDLE waits for start. ST_RD issues a read of one descriptor word and ST_CAP captures it, four times per descriptor. ST_SUSP is entered when the status word shows software ownership. ST_RECV accepts frame bytes. ST_FLUSH lets the final data word drain. ST_WB writes the status word. The transitions are: IDLE to RD on start; RD to CAP always; CAP to SUSP on a software-owned status, CAP to RECV after the fourth word, otherwise CAP back to RD; SUSP to RD on a poll demand and SUSP to IDLE when start is cleared; RECV to FLUSH once the last byte has been taken; FLUSH to WB; and WB to RD for the next descriptor.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset the block makes no memory access and stores no stream bytes until the start bit (register select 2, data bit 0) is written as 1.
- R2: After start, the first memory access is a read of the word at the descriptor base address (register select 0).
- R3: A descriptor whose status bit 31 is 0 is not used. The block suspends, writes nothing and drops incoming frames.
- R4: Frame bytes are packed little-endian into 32-bit words, with byte n at word (buffer address + n/4) and lane n mod 4. Unused lanes of the final word are written as zero.
- R5: The status write-back has bit 31 = 0, the frame length in bits [29:16], and bits 9 and 8 set.
- R6: Only the first control[10:0] bytes are stored. Words past that limit are untouched. A longer frame sets status bits 14 (truncated) and 15 (error summary), and the full length is still reported.
- R7: An error input that is high with the last byte sets status bits 1 and 15.
- R8: The status word is written only after the frame's last data word has been stored.
- R9: The next descriptor is the base address if control bit 25 is set. Otherwise it is the next-pointer word if control bit 24 is set. Otherwise it is the current descriptor address plus 4.
- R10: A frame whose first byte arrives while no descriptor is ready is dropped entirely, even if a descriptor becomes ready while the frame is still arriving.
- R11: While suspended, the block resumes only on a poll demand (any write to register select 1) and then re-reads the same descriptor.
- R12: The memory port never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 base, 1 poll, 2 start |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Last byte of frame |
| in_err | input | 1 | Frame error, sampled with the last byte |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after mem_rd |

## Verification
A register write takes effect one cycle later. A descriptor fetch then takes eight cycles before bytes are accepted. A full data word reaches memory one cycle after the byte that completes it. The status word is written two cycles after the last byte is taken, so it is in memory by the third clock edge after that byte. The bench drives and samples 1 ns after rising edges. It waits at least 25 cycles after each frame or poll before it reads the memory model, and it starts a frame only once the next fetch has had time to finish. The mid-frame poll case is timed so that the descriptor becomes ready while the dropped frame is still arriving.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int LEN_W  = 14;
    localparam int SIZE_W = 11;
    localparam int BIT_OWN   = 31;
    localparam int BIT_CHAIN = 24;
    localparam int BIT_REND  = 25;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD, ST_CAP, ST_SUSP, ST_RECV, ST_FLUSH, ST_WB
    } rxd_state_t;

    function automatic logic [31:0] make_status(input logic [LEN_W-1:0] len,
                                                input logic trunc, input logic crc);
        return {2'b00, len, (trunc | crc), trunc, 4'b0000, 2'b11, 6'b000000, crc, 1'b0};
    endfunction
endpackage

// File: rtl/rxd_regs.sv
module rxd_regs #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    output logic [AW-1:0] base,
    output logic          run,
    output logic          poll
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            run  <= 1'b0;
            poll <= 1'b0;
        end else begin
            poll <= reg_wr && (reg_sel == 2'd1);
            if (reg_wr && reg_sel == 2'd0) base <= reg_wdata[AW-1:0];
            if (reg_wr && reg_sel == 2'd2) run  <= reg_wdata[0];
        end
    end
endmodule

// File: rtl/rxd_pack.sv
module rxd_pack import rxd_pkg::*; #(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              clear,
    input  logic [AW-1:0]     buf_addr,
    input  logic [SIZE_W-1:0] buf_size,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              in_err,
    output logic              pend,
    output logic [AW-1:0]     waddr,
    output logic [31:0]       wdata,
    output logic              done,
    output logic [LEN_W-1:0]  len,
    output logic              trunc,
    output logic              crc
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    logic              skip;
    logic              take;
    logic              store;
    logic [1:0]        lane;
    logic [31:0]       nword;
    logic              word_end;

    assign take  = in_valid && accept && !skip;
    assign store = ({{(LEN_W-SIZE_W){1'b0}}, buf_size} > len);
    assign lane  = len[1:0];
    assign word_end = (lane == 2'd3) || in_last
                   || ({{(LEN_W-SIZE_W){1'b0}}, buf_size} == len + 1'b1);

    always_comb begin
        nword = (lane == 2'd0) ? 32'h0 : wdata;
        nword[lane*8 +: 8] = in_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip  <= 1'b0;
            pend  <= 1'b0;
            done  <= 1'b0;
            waddr <= '0;
            wdata <= '0;
            len   <= '0;
            trunc <= 1'b0;
            crc   <= 1'b0;
        end else begin
            pend <= 1'b0;
            done <= 1'b0;
            if (clear) begin
                len   <= '0;
                trunc <= 1'b0;
                crc   <= 1'b0;
            end
            if (in_valid && (!accept || skip)) begin
                skip <= !in_last;
            end else if (take) begin
                if (store) begin
                    wdata <= nword;
                    pend  <= word_end;
                    waddr <= buf_addr + AW'(len >> 2);
                end else begin
                    trunc <= 1'b1;
                end
                if (len != LEN_MAX) len <= len + 1'b1;
                if (in_last) begin
                    done <= 1'b1;
                    crc  <= in_err;
                end
            end
        end
    end

    // R6: every stored word lies inside the buffer limit
    p_in_buffer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> ((32'(waddr - buf_addr) << 2) < 32'(buf_size)));
endmodule

// File: rtl/rxd_ctl.sv
module rxd_ctl import rxd_pkg::*; #(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              poll,
    input  logic [AW-1:0]     base,
    input  logic [31:0]       mem_rdata,
    input  logic              pk_pend,
    input  logic [AW-1:0]     pk_waddr,
    input  logic [31:0]       pk_wdata,
    input  logic              pk_done,
    input  logic [LEN_W-1:0]  pk_len,
    input  logic              pk_trunc,
    input  logic              pk_crc,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              accept,
    output logic              clear,
    output logic [AW-1:0]     buf_addr,
    output logic [SIZE_W-1:0] buf_size
);
    rxd_state_t    st, st_nx;
    logic [1:0]    k;
    logic [AW-1:0] desc;
    logic [AW-1:0] nxt;
    logic          chain, rend;
    logic [AW-1:0] desc_follow;

    assign desc_follow = rend ? base : (chain ? nxt : desc + AW'(4));

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (run) st_nx = ST_RD;
            ST_RD:    st_nx = ST_CAP;
            ST_CAP: begin
                if (k == 2'd0 && !mem_rdata[BIT_OWN]) st_nx = ST_SUSP;
                else if (k == 2'd3)                   st_nx = ST_RECV;
                else                                  st_nx = ST_RD;
            end
            ST_SUSP: begin
                if (!run)      st_nx = ST_IDLE;
                else if (poll) st_nx = ST_RD;
            end
            ST_RECV:  if (pk_done) st_nx = ST_FLUSH;
            ST_FLUSH: st_nx = ST_WB;
            ST_WB:    st_nx = ST_RD;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k        <= '0;
            desc     <= '0;
            nxt      <= '0;
            buf_addr <= '0;
            buf_size <= '0;
            chain    <= 1'b0;
            rend     <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    desc <= base;
                    k    <= '0;
                end
                ST_CAP: begin
                    unique case (k)
                        2'd1: begin
                            buf_size <= mem_rdata[SIZE_W-1:0];
                            chain    <= mem_rdata[BIT_CHAIN];
                            rend     <= mem_rdata[BIT_REND];
                        end
                        2'd2: buf_addr <= mem_rdata[AW-1:0];
                        2'd3: nxt      <= mem_rdata[AW-1:0];
                        default: ;
                    endcase
                    k <= (k == 2'd0 && !mem_rdata[BIT_OWN]) ? 2'd0 : k + 2'd1;
                end
                ST_WB: begin
                    desc <= desc_follow;
                    k    <= '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        accept    = 1'b0;
        clear     = 1'b0;
        unique case (st)
            ST_RD: begin
                mem_rd   = 1'b1;
                mem_addr = desc + AW'(k);
            end
            ST_RECV, ST_FLUSH: begin
                mem_wr    = pk_pend;
                mem_addr  = pk_waddr;
                mem_wdata = pk_wdata;
                accept    = (st == ST_RECV) && !pk_done;
            end
            ST_WB: begin
                mem_wr    = 1'b1;
                mem_addr  = desc;
                mem_wdata = make_status(pk_len, pk_trunc, pk_crc);
                clear     = 1'b1;
            end
            default: ;
        endcase
    end

    // R12: single-ported access
    p_no_rdwr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R2: start leads to a read of the base word
    p_start_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && run) |=> (mem_rd && mem_addr == $past(base)));
    // R3: a software-owned status blocks byte acceptance
    p_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAP && k == 2'd0 && !mem_rdata[BIT_OWN]) |=> !accept && !mem_wr);
    // R11: poll while suspended re-reads the same descriptor status
    p_resume_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP && poll && run) |=> (mem_rd && mem_addr == $past(desc)));
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma import rxd_pkg::*; #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          in_err,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata
);
    logic              run, poll;
    logic [AW-1:0]     base;
    logic              accept, clear;
    logic [AW-1:0]     buf_addr;
    logic [SIZE_W-1:0] buf_size;
    logic              pk_pend, pk_done, pk_trunc, pk_crc;
    logic [AW-1:0]     pk_waddr;
    logic [31:0]       pk_wdata;
    logic [LEN_W-1:0]  pk_len;

    rxd_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .base(base), .run(run), .poll(poll)
    );

    rxd_pack #(.AW(AW)) u_pack (
        .clk(clk), .rst_n(rst_n), .accept(accept), .clear(clear),
        .buf_addr(buf_addr), .buf_size(buf_size),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
        .pend(pk_pend), .waddr(pk_waddr), .wdata(pk_wdata), .done(pk_done),
        .len(pk_len), .trunc(pk_trunc), .crc(pk_crc)
    );

    rxd_ctl #(.AW(AW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .run(run), .poll(poll), .base(base),
        .mem_rdata(mem_rdata), .pk_pend(pk_pend), .pk_waddr(pk_waddr),
        .pk_wdata(pk_wdata), .pk_done(pk_done), .pk_len(pk_len),
        .pk_trunc(pk_trunc), .pk_crc(pk_crc),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .accept(accept), .clear(clear), .buf_addr(buf_addr), .buf_size(buf_size)
    );

    // R8: status write-back never overlaps a pending or just-finished data word
    p_status_after_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> (!pk_pend && !pk_done));
    // R10: data words come only from bytes taken while a descriptor was ready
    p_accept_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pk_pend |-> $past(accept));
endmodule

// File: tb/sim_rx_ring_dma.sv
`timescale 1ns/1ps
module sim_rx_ring_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
    logic [7:0]  in_data = '0;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        tb_we = 1'b0;
    logic [7:0]  tb_a = '0;
    logic [31:0] tb_d = '0;
    logic [31:0] mem [0:255];
    int          acc_cnt = 0;
    logic [31:0] first_rd = 32'hFFFF_FFFF;
    logic        seen_rd = 1'b0;
    int          errors = 0, checks = 0;
    logic [7:0]  fb [0:63];
    logic        finished = 1'b0;

    always #2.5 clk = ~clk;

    rx_ring_dma u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (tb_we) mem[tb_a] <= tb_d;
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (rst_n && (mem_rd || mem_wr)) acc_cnt <= acc_cnt + 1;
        if (rst_n && mem_rd && !seen_rd) begin
            seen_rd  <= 1'b1;
            first_rd <= mem_addr;
        end
    end

    function automatic logic [31:0] sent(input int a);
        return 32'h5A00_0000 | 32'(a);
    endfunction

    function automatic logic [31:0] exp_status(input int len, input bit tr, input bit er);
        return (32'(len) << 16) | 32'h300 | ((tr || er) ? 32'h8000 : 0)
             | (tr ? 32'h4000 : 0) | (er ? 32'h2 : 0);
    endfunction

    function automatic logic [31:0] exp_word(input int w, input int n);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++)
            if (4*w + b < n) r[8*b +: 8] = fb[4*w + b];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic mset(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        tb_we = 1'b1; tb_a = 8'(a); tb_d = d;
        @(posedge clk); #1;
        tb_we = 1'b0;
    endtask

    task automatic regw(input logic [1:0] s, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic fill(input int len);
        for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    endtask

    task automatic send(input int len, input bit er, input int poll_at);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_data = fb[i];
            in_last = (i == len - 1); in_err = er && (i == len - 1);
            reg_wr = (i == poll_at); reg_sel = 2'd1;
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic check_buf(input int ba, input int n, input bit sentinel, input string req);
        bit ok = 1'b1;
        int nw = (n + 3) / 4;
        logic [31:0] bad_a = '0, bad_e = '0;
        for (int w = 0; w < nw; w++)
            if (mem[ba + w] !== exp_word(w, n)) begin
                ok = 1'b0; bad_a = mem[ba + w]; bad_e = exp_word(w, n);
            end
        check(ok, req, bad_a, bad_e);
        if (sentinel) check(mem[ba + nw] === sent(ba + nw), req, mem[ba + nw], sent(ba + nw));
    endtask

    initial begin
        int seed, len;
        logic [31:0] snap_s, snap_d;
        seed = int'($urandom(32'd11));
        for (int a = 0; a < 256; a++) mset(a, sent(a));
        // descriptors: D0 @16 chained to 40, D1 @40 sequential, D2 @44 ring end
        mset(16, 32'h8000_0000); mset(17, 32'd64 | (32'd1 << 24)); mset(18, 32'd100); mset(19, 32'd40);
        mset(40, 32'h8000_0000); mset(41, 32'd6);                  mset(42, 32'd120); mset(43, 32'd0);
        mset(44, 32'h8000_0000); mset(45, 32'd64 | (32'd1 << 25)); mset(46, 32'd140); mset(47, 32'd0);
        tick(3);
        rst_n = 1'b1;
        tick(2);
        regw(2'd0, 32'd16);
        // R1: nothing happens before start, even with a frame on the stream
        fill(8);
        send(8, 1'b0, -1);
        tick(20);
        check(acc_cnt == 0, "R1 no access before start", 32'(acc_cnt), 0);
        check(mem[100] === sent(100), "R1 buffer untouched", mem[100], sent(100));
        regw(2'd2, 32'd1);
        tick(25);
        check(first_rd === 32'd16, "R2 first read at base", first_rd, 32'd16);
        // F1: random frame into D0
        len = 1 + int'($urandom % 40);
        fill(len);
        send(len, 1'b0, -1);
        tick(25);
        check_buf(100, len, 1'b1, "R4 packing D0");
        check(mem[16] === exp_status(len, 0, 0), "R5 status D0", mem[16], exp_status(len, 0, 0));
        // F2: 13 bytes into 6-byte buffer with error flag
        fill(13);
        send(13, 1'b1, -1);
        tick(25);
        check_buf(120, 6, 1'b1, "R6 truncation limit");
        check(mem[40] === exp_status(13, 1, 1), "R6 R7 truncated+crc status", mem[40], exp_status(13, 1, 1));
        // F3: sequential follow-on to 44 (R9)
        len = 1 + int'($urandom % 40);
        fill(len);
        send(len, 1'b0, -1);
        tick(25);
        check_buf(140, len, 1'b1, "R9 sequential next descriptor data");
        check(mem[44] === exp_status(len, 0, 0), "R9 status at 44", mem[44], exp_status(len, 0, 0));
        // ring end back to D0, which software still owns -> suspend (R3)
        snap_s = mem[16]; snap_d = mem[100];
        fill(10);
        send(10, 1'b0, -1);
        tick(25);
        check(mem[16] === snap_s, "R3 status kept while suspended", mem[16], snap_s);
        check(mem[100] === snap_d, "R3 frame dropped", mem[100], snap_d);
        // owner restored without poll: still suspended (R11)
        mset(16, 32'h8000_0000);
        fill(10);
        send(10, 1'b0, -1);
        tick(25);
        check(mem[16] === 32'h8000_0000, "R11 no resume without poll", mem[16], 32'h8000_0000);
        regw(2'd1, 32'd0);
        tick(25);
        len = 1 + int'($urandom % 40);
        fill(len);
        send(len, 1'b1, -1);
        tick(25);
        check(mem[16] === exp_status(len, 0, 1), "R11 R9 R7 resumed at base", mem[16], exp_status(len, 0, 1));
        check_buf(100, len, 1'b0, "R11 data after poll");
        // D1 is now software-owned: poll in the middle of a frame (R10)
        mset(41, 32'd64);
        mset(40, 32'h8000_0000);
        fill(24);
        send(24, 1'b0, 2);
        tick(25);
        check(mem[40] === 32'h8000_0000, "R10 mid-frame bytes dropped", mem[40], 32'h8000_0000);
        len = 1 + int'($urandom % 40);
        fill(len);
        send(len, 1'b0, -1);
        tick(25);
        check(mem[40] === exp_status(len, 0, 0), "R10 next frame stored whole", mem[40], exp_status(len, 0, 0));
        check_buf(120, len, 1'b0, "R4 R10 data D1");
        // R12 covered by assertion; R8: status is last write, seen via final status value
        check(mem[44][31] === 1'b0, "R8 status owner cleared", 32'(mem[44][31]), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule